// File: doc/BRIEF.md
# Scan Capture Sequencer

This block runs the phases of one scan test pattern on a short internal scan chain. After a start request it loads the chain serially, drops scan enable, fires the functional clock enable for the capture phase, and then unloads the chain while the next pattern may be loaded. The chain flops, the logic between them and the tester sit outside the block. The block only drives their control strobes and steers the serial data.

A mode input picks one of two pattern kinds when a pattern begins. In stuck-at mode the chain receives a single capture pulse after the primary inputs have been updated. In transition mode two pulses follow each other on consecutive cycles. The first pulse launches a transition and also updates the primary inputs. The second pulse captures the response. Scan enable is registered from the next-state decode, and a dedicated drop cycle makes sure it is already low before the first pulse. A hold output keeps memory write enables blocked while data moves through the chain.

The first pattern run after reset is a chain-integrity run. The block itself feeds a fixed bit sequence into the chain and compares what comes back at the serial output, with no capture pulse. Any mismatch sets a sticky error flag. Holding start high through the end of an unload chains the next pattern onto it: the unload has already loaded that pattern's data, so its load phase is skipped.

Top module: `scan_pattern_sequencer`

## Requirements
- R1: While reset is active and in the first cycle after reset, scan_en, cap_en, pi_update, mem_we_hold, done, chain_test and chain_err are all 0.
- R2: The first run after reset is a chain test. It has CHAIN_LEN load cycles followed by CHAIN_LEN unload cycles, then done. chain_test is high for all of these cycles, and cap_en stays 0. In shift cycle k of each phase (k from 0), chain_si carries bit 1 of k, which gives the repeating sequence 0,0,1,1. In unload cycle k, scan_out is expected to equal that same bit. Later runs are normal patterns until the next reset.
- R3: In a chain-test unload cycle where chain_so differs from the expected bit, chain_err goes high. It is visible no later than the done cycle and stays high until reset.
- R4: A stuck-at pattern (mode = 0) runs as follows: CHAIN_LEN load cycles, one drop cycle, exactly one cycle with cap_en = 1, CHAIN_LEN unload cycles, then one done cycle.
- R5: A transition pattern (mode = 1) has two cap_en cycles back to back after the drop cycle: first the launch cycle, then the capture cycle. Then come the unload and done cycles.
- R6: scan_en is 1 in every load and unload cycle. It is never 1 together with cap_en, and it is 0 in the cycle just before the first cap_en cycle.
- R7: pi_update is 1 for exactly one cycle per pattern. In transition mode that is the launch cycle. In stuck-at mode it is the drop cycle.
- R8: mem_we_hold is 1 in every load, drop and unload cycle. It is 0 in cap_en cycles and while idle.
- R9: In shift cycle k (k from 1) of a load or unload phase, shift_cnt equals CHAIN_LEN-k. shift_last is 1 exactly when shift_cnt is 0.
- R10: If start is high in the last unload cycle of a normal pattern, the next cycle is the drop cycle of a new pattern. That pattern uses the data shifted in during the unload, and no done cycle comes in between.
- R11: The mode is sampled only when a pattern begins, which is when leaving idle or when chaining in R10. Mode changes at any other time have no effect.
- R12: In normal shift cycles chain_si equals scan_in. scan_out always equals chain_so.
- R13: done is a single-cycle pulse and is followed by the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a pattern; held high to chain the next one |
| mode | input | 1 | Pattern kind: 0 stuck-at, 1 transition |
| scan_in | input | 1 | Serial data from the tester |
| chain_so | input | 1 | Serial output of the last chain flop |
| chain_si | output | 1 | Serial input to the first chain flop |
| scan_out | output | 1 | Serial data to the tester |
| scan_en | output | 1 | Chain shift enable |
| cap_en | output | 1 | Functional clock enable for the launch and capture pulses |
| pi_update | output | 1 | Strobe to apply new primary input values |
| mem_we_hold | output | 1 | Blocks memory write enables |
| shift_cnt | output | $clog2(CHAIN_LEN) | Shift cycles remaining in the phase, minus one |
| shift_last | output | 1 | Shift counter terminal flag |
| chain_test | output | 1 | The chain-integrity run is in progress |
| done | output | 1 | Pattern finished pulse |
| chain_err | output | 1 | Sticky chain-test mismatch flag |

## Verification
Start is sampled at a rising edge. The first load cycle is the next cycle, and every control output is registered from the next-state decode, so each strobe shows up in the cycle of the phase it belongs to. For a chain of N flops, the drop cycle is cycle N+1 after start, the pulse or pulses follow, and unload and done come after them. A chain-test mismatch shows on chain_err one edge after the failing cycle, which is no later than done. The bench drives inputs and samples every output at the falling edge. It counts cycles from the start edge and works out the unload words arithmetically from the loaded word and the primary input values. It sweeps all 256 load words for an 8-flop chain in both modes.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_LOAD   = 3'd1,
      SQ_SEDROP = 3'd2,
      SQ_LAUNCH = 3'd3,
      SQ_CAPT   = 3'd4,
      SQ_UNLOAD = 3'd5,
      SQ_DONE   = 3'd6
   } sq_state_e;

   typedef enum logic {
      PM_STUCK = 1'b0,
      PM_TRANS = 1'b1
   } pat_mode_e;

   function automatic logic is_shift(sq_state_e s);
      return (s == SQ_LOAD) || (s == SQ_UNLOAD);
   endfunction

endpackage

// File: rtl/scanseq_shift_ctr.sv
module scanseq_shift_ctr #(
   parameter int LEN = 8,
   parameter int CW  = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          dec,
   output logic [CW-1:0] cnt,
   output logic          last
);

   localparam logic [CW-1:0] TOP = CW'(LEN - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= TOP;
      else if (dec && (cnt != '0))
         cnt <= cnt - 1'b1;
   end

   assign last = (cnt == '0);

   // R9: a phase starts from the top count
   p_load_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == TOP));

   // R9: one step down per shift cycle
   p_step_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && !last) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/scanseq_fsm.sv
module scanseq_fsm
   import scanseq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic mode_in,
   input  logic cnt_last,
   output logic load_cnt,
   output logic dec_cnt,
   output logic in_unload,
   output logic scan_en,
   output logic cap_en,
   output logic pi_update,
   output logic mem_hold,
   output logic done,
   output logic chain_test
);

   sq_state_e state_q, state_d;
   pat_mode_e mode_q, mode_d;
   logic      ct_q, ct_d;
   logic      ct_pend;

   always_comb begin
      state_d = state_q;
      mode_d  = mode_q;
      ct_d    = ct_q;
      unique case (state_q)
         SQ_IDLE: begin
            if (start) begin
               state_d = SQ_LOAD;
               mode_d  = pat_mode_e'(mode_in);
               ct_d    = ct_pend;
            end
         end
         SQ_LOAD: begin
            if (cnt_last)
               state_d = ct_q ? SQ_UNLOAD : SQ_SEDROP;
         end
         SQ_SEDROP: state_d = (mode_q == PM_TRANS) ? SQ_LAUNCH : SQ_CAPT;
         SQ_LAUNCH: state_d = SQ_CAPT;
         SQ_CAPT:   state_d = SQ_UNLOAD;
         SQ_UNLOAD: begin
            if (cnt_last) begin
               if (!ct_q && start) begin
                  state_d = SQ_SEDROP;
                  mode_d  = pat_mode_e'(mode_in);
               end else begin
                  state_d = SQ_DONE;
               end
            end
         end
         SQ_DONE: begin
            state_d = SQ_IDLE;
            ct_d    = 1'b0;
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   assign load_cnt  = is_shift(state_d) && (state_d != state_q);
   assign dec_cnt   = is_shift(state_q);
   assign in_unload = (state_q == SQ_UNLOAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SQ_IDLE;
         mode_q     <= PM_STUCK;
         ct_q       <= 1'b0;
         ct_pend    <= 1'b1;
         scan_en    <= 1'b0;
         cap_en     <= 1'b0;
         pi_update  <= 1'b0;
         mem_hold   <= 1'b0;
         done       <= 1'b0;
      end else begin
         state_q    <= state_d;
         mode_q     <= mode_d;
         ct_q       <= ct_d;
         if ((state_q == SQ_UNLOAD) && cnt_last && ct_q)
            ct_pend <= 1'b0;
         scan_en    <= is_shift(state_d);
         cap_en     <= (state_d == SQ_LAUNCH) || (state_d == SQ_CAPT);
         pi_update  <= (state_d == SQ_LAUNCH) ||
                       ((state_d == SQ_SEDROP) && (mode_d == PM_STUCK));
         mem_hold   <= is_shift(state_d) || (state_d == SQ_SEDROP);
         done       <= (state_d == SQ_DONE);
      end
   end

   assign chain_test = ct_q;

   // R6: shift and pulse never overlap
   p_no_se_with_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |-> !scan_en);

   // R6: scan enable already low one cycle ahead of the first pulse
   p_se_low_before_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && !$past(cap_en)) |-> !$past(scan_en));

   // R8: memory writes blocked whenever the chain moves
   p_hold_in_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |-> mem_hold);

   // R8: hold released for the pulses
   p_hold_off_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |-> !mem_hold);

   // R5: transition patterns pulse twice in a row
   p_trans_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && !$past(cap_en) && (mode_q == PM_TRANS)) |=> cap_en);

   // R4: stuck-at patterns pulse once
   p_stuck_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && (mode_q == PM_STUCK)) |=> !cap_en);

   // R2: the integrity run never pulses
   p_ct_no_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      chain_test |-> !cap_en);

   // R13: done lasts one cycle
   p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11: the mode register moves only where a pattern begins
   p_mode_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q != SQ_IDLE) && (state_q != SQ_UNLOAD)) |=> (mode_q == $past(mode_q)));

endmodule

// File: rtl/scanseq_chain_chk.sv
module scanseq_chain_chk #(
   parameter int LEN      = 8,
   parameter int CW       = 3,
   parameter int PAT_KIND = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ct_active,
   input  logic          unload,
   input  logic [CW-1:0] cnt,
   input  logic          chain_so,
   output logic          pat_bit,
   output logic          err
);

   logic [CW-1:0] idx;
   assign idx = CW'(LEN - 1) - cnt;

   generate
      if (PAT_KIND == 0) begin : g_pairs
         assign pat_bit = ((idx % 4) >= 2);
      end else if (PAT_KIND == 1) begin : g_alternate
         assign pat_bit = ((idx % 2) == 1);
      end else begin : g_parity
         assign pat_bit = ^idx;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err <= 1'b0;
      else if (ct_active && unload && (chain_so != pat_bit))
         err <= 1'b1;
   end

   // R3: the flag is sticky
   p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R3: the flag rises only from an integrity-run unload cycle
   p_err_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $past(ct_active && unload));

endmodule

// File: rtl/scan_pattern_sequencer.sv
module scan_pattern_sequencer #(
   parameter int CHAIN_LEN = 8,
   parameter int PAT_KIND  = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic                         mode,
   input  logic                         scan_in,
   input  logic                         chain_so,
   output logic                         chain_si,
   output logic                         scan_out,
   output logic                         scan_en,
   output logic                         cap_en,
   output logic                         pi_update,
   output logic                         mem_we_hold,
   output logic [$clog2(CHAIN_LEN)-1:0] shift_cnt,
   output logic                         shift_last,
   output logic                         chain_test,
   output logic                         done,
   output logic                         chain_err
);

   localparam int CW = $clog2(CHAIN_LEN);

   generate
      if (CHAIN_LEN < 4) begin : g_len_check
         $error("CHAIN_LEN must be at least 4");
      end
      if ((PAT_KIND < 0) || (PAT_KIND > 2)) begin : g_kind_check
         $error("PAT_KIND must be 0, 1 or 2");
      end
   endgenerate

   logic load_cnt, dec_cnt, in_unload, cnt_last, pat_bit;

   scanseq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .mode_in    (mode),
      .cnt_last   (cnt_last),
      .load_cnt   (load_cnt),
      .dec_cnt    (dec_cnt),
      .in_unload  (in_unload),
      .scan_en    (scan_en),
      .cap_en     (cap_en),
      .pi_update  (pi_update),
      .mem_hold   (mem_we_hold),
      .done       (done),
      .chain_test (chain_test)
   );

   scanseq_shift_ctr #(.LEN(CHAIN_LEN), .CW(CW)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_cnt),
      .dec   (dec_cnt),
      .cnt   (shift_cnt),
      .last  (cnt_last)
   );

   scanseq_chain_chk #(.LEN(CHAIN_LEN), .CW(CW), .PAT_KIND(PAT_KIND)) u_chk (
      .clk       (clk),
      .rst_n     (rst_n),
      .ct_active (chain_test),
      .unload    (in_unload),
      .cnt       (shift_cnt),
      .chain_so  (chain_so),
      .pat_bit   (pat_bit),
      .err       (chain_err)
   );

   assign shift_last = cnt_last;
   assign chain_si   = chain_test ? pat_bit : scan_in;
   assign scan_out   = chain_so;

endmodule

// File: tb/scan_pattern_sequencer_test.sv
module scan_pattern_sequencer_test;

   localparam int N      = 8;
   localparam int CW     = $clog2(N);
   localparam int T_CLK  = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, mode = 1'b0, scan_in = 1'b0;
   logic chain_so, chain_si, scan_out, scan_en, cap_en, pi_update, mem_we_hold;
   logic [CW-1:0] shift_cnt;
   logic shift_last, chain_test, done, chain_err;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;
   bit fault = 0;

   logic [N-1:0] chain, chain_v, pi_q, pi_next;

   always #(T_CLK/2) clk = ~clk;

   scan_pattern_sequencer #(.CHAIN_LEN(N), .PAT_KIND(0)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .scan_in(scan_in),
      .chain_so(chain_so), .chain_si(chain_si), .scan_out(scan_out),
      .scan_en(scan_en), .cap_en(cap_en), .pi_update(pi_update),
      .mem_we_hold(mem_we_hold), .shift_cnt(shift_cnt), .shift_last(shift_last),
      .chain_test(chain_test), .done(done), .chain_err(chain_err)
   );

   // chain and logic model: bit 3 optionally stuck at 0
   assign chain_v  = fault ? (chain & ~(N'(1) << 3)) : chain;
   assign chain_so = chain_v[N-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         pi_q  <= '0;
      end else begin
         if (scan_en)
            chain <= {chain_v[N-2:0], chain_si};
         else if (cap_en)
            chain <= {chain_v[N-2:0], chain_v[N-1]} ^ pi_q;
         if (pi_update)
            pi_q <= pi_next;
      end
   end

   function automatic logic [N-1:0] resp(input logic [N-1:0] x, input logic [N-1:0] p);
      return {x[N-2:0], x[N-1]} ^ p;
   endfunction

   function automatic logic pat(input int k);
      return ((k >> 1) & 1) == 1;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic ctl(input string ph, input logic se, input logic ce,
                      input logic pu, input logic mh, input logic dn);
      chk({"R6 scan_en ", ph}, 32'(scan_en), 32'(se));
      chk({"R4/R5 cap_en ", ph}, 32'(cap_en), 32'(ce));
      chk({"R7 pi_update ", ph}, 32'(pi_update), 32'(pu));
      chk({"R8 mem_we_hold ", ph}, 32'(mem_we_hold), 32'(mh));
      chk({"R13 done ", ph}, 32'(done), 32'(dn));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; start = 1'b0; scan_in = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 chain_err in reset", 32'(chain_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      ctl("R1 after reset", 0, 0, 0, 0, 0);
      chk("R1 chain_test", 32'(chain_test), 0);
      chk("R1 chain_err", 32'(chain_err), 0);
   endtask

   task automatic run_ct(input bit chk_so, input bit exp_err);
      @(negedge clk);
      start = 1'b1; mode = 1'b0;
      for (int j = 1; j <= 2*N; j++) begin
         @(negedge clk);
         if (j == 1) start = 1'b0;
         ctl("R2 integrity shift", 1, 0, 0, 1, 0);
         chk("R2 chain_test", 32'(chain_test), 1);
         chk("R9 shift_cnt integrity", 32'(shift_cnt), (j <= N) ? N - j : 2*N - j);
         if (j <= N)
            chk("R2 chain_si load", 32'(chain_si), 32'(pat(j-1)));
         else if (chk_so)
            chk("R2 scan_out unload", 32'(scan_out), 32'(pat(j-N-1)));
      end
      @(negedge clk);
      ctl("R2 integrity done", 0, 0, 0, 0, 1);
      chk("R3 chain_err at done", 32'(chain_err), 32'(exp_err));
      @(negedge clk);
      ctl("R13 idle after done", 0, 0, 0, 0, 0);
   endtask

   task automatic run_pat(input bit first, input bit md, input logic [N-1:0] ld,
                          input logic [N-1:0] npi, input bit keep, input bit nmd,
                          input logic [N-1:0] nld, input bit flip);
      logic [N-1:0] exp_w;
      string rq;
      rq = md ? "R5" : "R4";
      exp_w = md ? resp(resp(ld, pi_q), npi) : resp(ld, npi);
      pi_next = npi;
      if (first) begin
         @(negedge clk);
         mode = md; start = 1'b1;
         for (int j = 1; j <= N; j++) begin
            @(negedge clk);
            if (j == 1) start = keep;
            if (flip && j == 3) mode = ~md;
            ctl({rq, " load"}, 1, 0, 0, 1, 0);
            chk("R9 shift_cnt load", 32'(shift_cnt), N - j);
            chk("R9 shift_last load", 32'(shift_last), 32'(j == N));
            chk("R2 no integrity run", 32'(chain_test), 0);
            scan_in = ld[N-j];
            #1;
            chk("R12 chain_si", 32'(chain_si), 32'(ld[N-j]));
         end
      end
      @(negedge clk);
      start = keep;
      ctl({rq, " drop R10/R11"}, 0, 0, 32'(!md), 1, 0);
      if (md) begin
         @(negedge clk);
         ctl("R5 launch", 0, 1, 1, 0, 0);
      end
      @(negedge clk);
      ctl({rq, " capture"}, 0, 1, 0, 0, 0);
      for (int j = 1; j <= N; j++) begin
         @(negedge clk);
         ctl({rq, " unload"}, 1, 0, 0, 1, 0);
         chk("R9 shift_cnt unload", 32'(shift_cnt), N - j);
         chk({rq, " R12 scan_out"}, 32'(scan_out), 32'(exp_w[N-j]));
         scan_in = keep ? nld[N-j] : 1'b0;
         if (keep && j == 1) mode = nmd;
      end
      if (!keep) begin
         @(negedge clk);
         ctl({rq, " done"}, 0, 0, 0, 0, 1);
         chk("R2 chain_test in done", 32'(chain_test), 0);
         @(negedge clk);
         ctl("R13 idle", 0, 0, 0, 0, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog R13: got no finish expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      pi_next = '0;
      do_reset();
      run_ct(1'b1, 1'b0);                                           // R2
      run_pat(1, 0, 8'hA5, 8'h3C, 0, 0, 8'h00, 0);                  // R4 R7
      run_pat(1, 1, 8'h5A, 8'h81, 0, 0, 8'h00, 1);                  // R5 R11
      run_pat(1, 0, 8'hC3, 8'h0F, 1, 1, 8'h96, 0);                  // R10 A
      run_pat(0, 1, 8'h96, 8'hF0, 1, 0, 8'h3B, 1);                  // R10 B, chains again
      run_pat(0, 0, 8'h3B, 8'h77, 0, 0, 8'h00, 0);                  // R10 C
      for (int v = 0; v < 256; v++) begin
         for (int m = 0; m < 2; m++) begin
            run_pat(1, m[0], 8'(v), 8'(v * 37 + m * 91 + 5), 0, 0, 8'h00, 0);
         end
      end
      // R3: faulty chain flags an error that persists
      fault = 1;
      do_reset();
      run_ct(1'b0, 1'b1);
      repeat (5) @(negedge clk);
      chk("R3 chain_err sticky", 32'(chain_err), 1);
      fault = 0;
      do_reset();
      chk("R3 chain_err cleared", 32'(chain_err), 0);
      run_ct(1'b1, 1'b0);                                           // R2 after reset again
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule